// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a 48-bit virtual address into a physical frame once the translation cache has missed. It takes one walk request at a time, together with the frame number of the current process's root table. It then issues one 64-bit read per table level over a valid/ready read port. Each returned entry is checked. A walk ends in one of two ways. A present entry at the last level yields a fill record holding the frame number, the access permissions, and the dirty and referenced flags. A not-present entry at any level yields a fault carrying the level where the walk stopped.

Pages are 4 KB, so the low 12 address bits never take part in the walk. The remaining 36-bit virtual page number is cut into four 9-bit indexes, which are consumed from the top field downward. Each table holds 512 eight-byte entries. A read address is therefore the table's frame number followed by the 9-bit index and three zero bits. Read responses arrive as a one-cycle pulse, after any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: `reqReady` is high only while the walker is idle. An accepted request (`reqValid` and `reqReady` high at a clock edge) raises `busy` in the next cycle. `busy` stays high until the cycle in which `fillValid` or `fault` pulses, and it is low in that cycle. A request offered while busy is not taken.
- R2: The first read goes out in the cycle after acceptance, at address {`ptBase`, vaddr[47:39], 3'b000}. The root frame number occupies bits 51:12 and the index occupies bits 11:3.
- R3: The reads for levels 1, 2 and 3 use vaddr[38:30], vaddr[29:21] and vaddr[20:12] as the index. Each uses bits 51:12 of the previous level's entry as the table frame number. The next read is presented in the cycle after the previous response.
- R4: `memReqValid` is held high with `memReqAddr` unchanged until `memReqReady` is sampled high. Exactly one read is made per level visited.
- R5: An entry whose bit 0 is clear ends the walk. `fault` pulses in the cycle after that response, with `faultLevel` giving the level (0 to 3). No further read is issued and no fill occurs.
- R6: A present level-3 entry pulses `fillValid` in the cycle after its response, with these fields taken from the entry:
  - `fillFrame` = bits 51:12;
  - `fillPerm` = bits 3:1 (bit 1 read, bit 2 write, bit 3 execute);
  - `fillRef` = bit 4 and `fillDirty` = bit 5;
  - `fillVpn` = vaddr[47:12].
  Entry bits 63:52 and 11:6 are ignored.
- R7: `fillValid` and `fault` each last one cycle and are never high together.
- R8: A `memRspValid` pulse that arrives while no read is outstanding is ignored.
- R9: `reqVaddr` and `ptBase` are sampled only at acceptance. Later changes to them do not affect the walk.
- R10: After reset the walker is idle: `reqReady` is high and `busy`, `memReqValid`, `fillValid` and `fault` are low.
- R11: Any response latency, from the cycle right after the read handshake upward, is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request offered |
| reqReady | output | 1 | Walker idle, request can be taken |
| reqVaddr | input | 48 | Virtual address to translate |
| ptBase | input | 40 | Frame number of the root table |
| busy | output | 1 | Walk in progress |
| memReqValid | output | 1 | Table read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 52 | Physical byte address of the entry |
| memRspValid | input | 1 | One-cycle read data pulse |
| memRspData | input | 64 | Entry read from memory |
| fillValid | output | 1 | One-cycle translation result pulse |
| fillVpn | output | 36 | Virtual page number of the finished walk |
| fillFrame | output | 40 | Physical frame number |
| fillPerm | output | 3 | Execute, write, read permissions |
| fillRef | output | 1 | Referenced flag |
| fillDirty | output | 1 | Dirty flag |
| fault | output | 1 | One-cycle page fault pulse |
| faultLevel | output | 2 | Level whose entry was not present |

## Verification
Each result has a fixed due cycle. The first read address is due in the cycle after acceptance. Every later read address is due in the cycle after the previous response. The fill or fault pulse is due in the cycle after the last response, and it is gone one cycle later. The bench drives inputs and samples outputs on the falling edge. Its checks fall at exactly those falling edges, after a chosen number of stall and latency cycles. It also checks during the stalls that the address holds and that nothing was produced early.

// File: rtl/walker_pkg.sv
`timescale 1ns/1ps
package walker_pkg;
  parameter int VA_W       = 48;
  parameter int PA_W       = 52;
  parameter int PTE_W      = 64;
  parameter int PAGE_OFS_W = 12;
  parameter int IDX_W      = 9;
  parameter int LEVELS     = 4;
  parameter int PTE_BYTES_LOG = 3;

  localparam int VPN_W  = VA_W - PAGE_OFS_W;
  localparam int PPN_W  = PA_W - PAGE_OFS_W;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int PERM_W = 3;

  // entry bit positions
  localparam int BIT_PRESENT = 0;
  localparam int BIT_PERM_LO = 1;
  localparam int BIT_REF     = 4;
  localparam int BIT_DIRTY   = 5;
  localparam int FLAG_TOP    = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch request and root base
    logic descend;   // move to next level with entry base
    logic finish;    // emit fill record
    logic flag;      // emit page fault
  } walkStrb_t;
endpackage

// File: rtl/walk_ctrl.sv
`timescale 1ns/1ps
module walk_ctrl
  import walker_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      entryPresent,
  input  logic      atLastLevel,
  output logic      reqReady,
  output logic      memReqValid,
  output logic      busy,
  output walkStrb_t strb
);
  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strb.capture = 1'b1;
        stateNext    = ST_REQ;
      end
      ST_REQ: if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) begin
        if (!entryPresent) begin
          strb.flag = 1'b1;
          stateNext = ST_IDLE;
        end else if (atLastLevel) begin
          strb.finish = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          strb.descend = 1'b1;
          stateNext    = ST_REQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_REQ);
  assign busy        = (state != ST_IDLE);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (busy && memReqValid));

  p_hold_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  p_rsp_outcome_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && memRspValid && !entryPresent) |=> !busy);
endmodule

// File: rtl/walk_dpath.sv
`timescale 1ns/1ps
module walk_dpath
  import walker_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrb_t         strb,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [PPN_W-1:0]  ptBase,
  input  logic [PTE_W-1:0]  memRspData,
  output logic [PA_W-1:0]   memReqAddr,
  output logic              entryPresent,
  output logic              atLastLevel,
  output logic              fillValid,
  output logic [VPN_W-1:0]  fillVpn,
  output logic [PPN_W-1:0]  fillFrame,
  output logic [PERM_W-1:0] fillPerm,
  output logic              fillRef,
  output logic              fillDirty,
  output logic              fault,
  output logic [LVL_W-1:0]  faultLevel
);
  logic [VPN_W-1:0] vpnQ;
  logic [PPN_W-1:0] tblBase;
  logic [LVL_W-1:0] level;
  logic [IDX_W-1:0] idxTbl [LEVELS];
  logic [IDX_W-1:0] curIdx;
  logic [PPN_W-1:0] entryPpn;
  logic             unusedBits;

  // one index field per level, top field first
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxTbl[g] = vpnQ[VPN_W-1-g*IDX_W -: IDX_W];
  end

  assign curIdx       = idxTbl[level];
  assign entryPpn     = memRspData[PA_W-1:PAGE_OFS_W];
  assign entryPresent = memRspData[BIT_PRESENT];
  assign atLastLevel  = (level == LVL_W'(LEVELS-1));
  assign memReqAddr   = {tblBase, curIdx, {PTE_BYTES_LOG{1'b0}}};
  assign unusedBits   = ^{memRspData[PTE_W-1:PA_W],
                          memRspData[PAGE_OFS_W-1:FLAG_TOP+1],
                          reqVaddr[PAGE_OFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ    <= '0;
      tblBase <= '0;
      level   <= '0;
    end else if (strb.capture) begin
      vpnQ    <= reqVaddr[VA_W-1:PAGE_OFS_W];
      tblBase <= ptBase;
      level   <= '0;
    end else if (strb.descend) begin
      tblBase <= entryPpn;
      level   <= level + LVL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillValid  <= 1'b0;
      fault      <= 1'b0;
      fillVpn    <= '0;
      fillFrame  <= '0;
      fillPerm   <= '0;
      fillRef    <= 1'b0;
      fillDirty  <= 1'b0;
      faultLevel <= '0;
    end else begin
      fillValid <= strb.finish;
      fault     <= strb.flag;
      if (strb.finish || strb.flag) fillVpn <= vpnQ;
      if (strb.finish) begin
        fillFrame <= entryPpn;
        fillPerm  <= memRspData[BIT_PERM_LO +: PERM_W];
        fillRef   <= memRspData[BIT_REF];
        fillDirty <= memRspData[BIT_DIRTY];
      end
      if (strb.flag) faultLevel <= level;
    end
  end

  p_root_base_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (memReqAddr[PA_W-1:PAGE_OFS_W] == $past(ptBase)));

  p_next_base_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.descend |=> (memReqAddr[PA_W-1:PAGE_OFS_W] == $past(entryPpn)));

  p_fill_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> !fillValid);

  p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> !fault);

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(fillValid && fault));
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import walker_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [PPN_W-1:0]  ptBase,
  output logic              busy,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [PA_W-1:0]   memReqAddr,
  input  logic              memRspValid,
  input  logic [PTE_W-1:0]  memRspData,
  output logic              fillValid,
  output logic [VPN_W-1:0]  fillVpn,
  output logic [PPN_W-1:0]  fillFrame,
  output logic [PERM_W-1:0] fillPerm,
  output logic              fillRef,
  output logic              fillDirty,
  output logic              fault,
  output logic [LVL_W-1:0]  faultLevel
);
  walkStrb_t strb;
  logic      entryPresent;
  logic      atLastLevel;

  walk_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .entryPresent(entryPresent),
    .atLastLevel (atLastLevel),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .busy        (busy),
    .strb        (strb)
  );

  walk_dpath dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqVaddr    (reqVaddr),
    .ptBase      (ptBase),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .entryPresent(entryPresent),
    .atLastLevel (atLastLevel),
    .fillValid   (fillValid),
    .fillVpn     (fillVpn),
    .fillFrame   (fillFrame),
    .fillPerm    (fillPerm),
    .fillRef     (fillRef),
    .fillDirty   (fillDirty),
    .fault       (fault),
    .faultLevel  (faultLevel)
  );

  p_fill_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> !busy);

  p_fault_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!busy && !memReqValid));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  typedef struct packed {
    logic [47:0] va;
    logic [39:0] base;
    logic [63:0] e0;
    logic [63:0] e1;
    logic [63:0] e2;
    logic [63:0] e3;
    logic [3:0]  stall;
    logic [3:0]  lat;
  } vec_t;

  // entry layout: bits 51:12 frame, 5 dirty, 4 ref, 3:1 x/w/r, 0 present
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{48'h1234_5678_9ABC, 40'h00_0000_0010,
      64'h000_0000000100_001, 64'h000_0000000200_001,
      64'h000_0000000300_001, 64'h000_00000ABCDE_017, 4'd0, 4'd0},
    '{48'h0000_7FFF_F000, 40'h00_0000_0020,
      64'h000_0000000111_003, 64'h000_0000000222_005,
      64'h000_0000000333_009, 64'h000_0000077777_02B, 4'd2, 4'd3},
    '{48'hABCD_EF01_2345, 40'h00_0000_0030,
      64'h000_0000000500_03E, 64'h000_0000000600_001,
      64'h000_0000000700_001, 64'h000_0000000800_001, 4'd1, 4'd0},
    '{48'h5555_AAAA_5555, 40'h12_3456_7890,
      64'h000_0000000A00_001, 64'h000_0000000B00_001,
      64'h000_0000000999_03E, 64'h000_0000000C00_001, 4'd1, 4'd1},
    '{48'h0001_0002_0003, 40'h00_0000_0040,
      64'h000_0000000D00_001, 64'h000_0000000E00_001,
      64'h000_0000000F00_001, 64'h000_0000012345_03E, 4'd0, 4'd2},
    '{48'hFFFF_FFFF_FFFF, 40'hFF_FFFF_FFFF,
      64'hFFF_8000000001_001, 64'hFFF_8000000002_001,
      64'hFFF_8000000003_001, 64'hFFF_FFFFFFFFFF_FFF, 4'd3, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqVaddr = '0;
  logic [39:0] ptBase = '0;
  logic        busy;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [51:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        fillValid;
  logic [35:0] fillVpn;
  logic [39:0] fillFrame;
  logic [2:0]  fillPerm;
  logic        fillRef;
  logic        fillDirty;
  logic        fault;
  logic [1:0]  faultLevel;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .ptBase(ptBase), .busy(busy),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .fillValid(fillValid), .fillVpn(fillVpn),
    .fillFrame(fillFrame), .fillPerm(fillPerm), .fillRef(fillRef),
    .fillDirty(fillDirty), .fault(fault), .faultLevel(faultLevel)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] idxOf(input logic [47:0] va, input int lvl);
    return va[47-9*lvl -: 9];
  endfunction

  task automatic runVec(input vec_t v);
    logic [63:0] ents [4];
    logic [39:0] base;
    logic [51:0] expAddr;
    int          stopL;
    bit          expFault;
    ents = '{v.e0, v.e1, v.e2, v.e3};
    expFault = 1'b0;
    stopL = 3;
    for (int l = 0; l < 4; l++) begin
      if (!expFault && !ents[l][0]) begin
        expFault = 1'b1;
        stopL = l;
      end
    end
    reqVaddr = v.va;
    ptBase   = v.base;
    reqValid = 1'b1;
    chk("R1 ready when idle", {63'd0, reqReady}, 64'd1);
    @(negedge clk);
    reqValid = 1'b0;
    ptBase   = ~v.base;      // R9: late change must not matter
    reqVaddr = ~v.va;
    chk("R1 busy after accept", {63'd0, busy}, 64'd1);
    base = v.base;
    for (int l = 0; l <= stopL; l++) begin
      expAddr = {base, idxOf(v.va, l), 3'b000};
      chk(l == 0 ? "R2 R9 root read" : "R3 level read", {12'd0, memReqAddr}, {12'd0, expAddr});
      chk("R4 read valid", {63'd0, memReqValid}, 64'd1);
      for (int s = 0; s < int'(v.stall); s++) begin
        if (s == 0) begin
          memRspValid = 1'b1;  // R8: stray response before handshake
          memRspData  = 64'd0;
        end
        @(negedge clk);
        memRspValid = 1'b0;
        chk("R4 held addr", {12'd0, memReqAddr}, {12'd0, expAddr});
        chk("R8 no stray result", {62'd0, fault, fillValid}, 64'd0);
        chk("R4 held valid", {63'd0, memReqValid}, 64'd1);
      end
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      chk("R4 one read", {63'd0, memReqValid}, 64'd0);
      for (int t = 0; t < int'(v.lat); t++) begin
        reqValid = 1'b1;
        chk("R1 no accept when busy", {63'd0, reqReady}, 64'd0);
        @(negedge clk);
        reqValid = 1'b0;
        chk("R11 waiting", {61'd0, memReqValid, fault, fillValid}, 64'd0);
      end
      memRspValid = 1'b1;
      memRspData  = ents[l];
      @(negedge clk);
      memRspValid = 1'b0;
      memRspData  = 64'd0;
      base = ents[l][51:12];
    end
    if (expFault) begin
      chk("R5 fault pulse", {63'd0, fault}, 64'd1);
      chk("R5 fault level", {62'd0, faultLevel}, 64'(stopL));
      chk("R5 no more reads", {62'd0, busy, memReqValid}, 64'd0);
      chk("R7 no fill on fault", {63'd0, fillValid}, 64'd0);
    end else begin
      chk("R6 fill pulse", {63'd0, fillValid}, 64'd1);
      chk("R6 frame", {24'd0, fillFrame}, {24'd0, v.e3[51:12]});
      chk("R6 perm", {61'd0, fillPerm}, {61'd0, v.e3[3:1]});
      chk("R6 ref dirty", {62'd0, fillDirty, fillRef}, {62'd0, v.e3[5], v.e3[4]});
      chk("R6 R9 vpn", {28'd0, fillVpn}, {28'd0, v.va[47:12]});
      chk("R1 idle at fill", {62'd0, busy, fault}, 64'd0);
    end
    @(negedge clk);
    chk("R7 one cycle", {62'd0, fault, fillValid}, 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R11 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {60'd0, memReqValid, busy, fillValid, fault}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", {63'd0, reqReady}, 64'd1);
    chk("R10 idle after reset", {61'd0, busy, memReqValid, fault}, 64'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // reset in the middle of a walk
    reqVaddr = 48'h0F0F_0F0F_0F0F;
    ptBase   = 40'h1;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R10 mid-walk reset", {61'd0, busy, memReqValid, reqReady}, 64'd1);
    @(negedge clk);
    memRspValid = 1'b1;   // stale response after reset
    memRspData  = 64'd0;
    @(negedge clk);
    memRspValid = 1'b0;
    chk("R8 stale response ignored", {61'd0, busy, fault, fillValid}, 64'd0);

    runVec(VECS[0]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule